// File: doc/BRIEF.md
# Pseudo-static RAM host controller

This block sits between a synchronous host and an asynchronous byte-wide pseudo-static RAM with a 16-bit address. The host issues one single-byte read or write at a time over a valid/ready handshake. Reads come back on a one-cycle response strobe. The controller drives the memory's chip enable, write strobe, combined output-enable/refresh line and address. It also drives a split data bus: an output byte, an input byte and a drive enable for an external tri-state buffer.

Every memory timing limit is met by counting clocks of period `CLK_NS`. All phase lengths are derived from nanosecond parameters at elaboration. After reset the controller observes the power-up quiet time, then runs a burst of dummy chip-enable cycles before it accepts host traffic. It then keeps the memory contents alive with periodic auto-refresh cycles. An auto-refresh is requested by pulling the output-enable line low while chip enable stays inactive. Each refresh is slotted in between host accesses and never cuts one short.

Top module: `psram_host_ctrl`

## Requirements
- R1: After reset, `psram_ce_n` and `psram_oe_n` stay high and `req_ready` stays low for at least `INIT_NS` (100 µs). Then exactly `DUMMY_CYCLES` (8) chip-enable low pulses, each with `psram_oe_n` and `psram_we_n` high, occur before `req_ready` first rises.
- R2: For each accepted read, `rsp_valid` pulses high for exactly one cycle. The pulse is registered on the clock edge that ends the chip-enable low phase, and `rsp_rdata` then holds the byte the memory returns for the request's address. Responses arrive one per read, in request order.
- R3: For a write, `psram_we_n` is low only while `psram_ce_n` is low, and it is low for the whole chip-enable low phase (at least 30 ns). `psram_dq_oe` is high with the request byte on `psram_dq_out` until `psram_we_n` rises, so the memory stores that byte at that edge.
- R4: `psram_addr` does not change while `psram_ce_n` is low.
- R5: Chip enable is low for 80 ns to 10 µs (8 clocks at the default 10 ns period). It is high for at least 50 ns between lows, and the spacing between successive falling edges is at least 140 ns. `psram_oe_n` is high at every falling edge of chip enable.
- R6: An auto-refresh drives `psram_oe_n` low with `psram_ce_n` high for 30 ns to 8 µs. It starts at least 50 ns after chip enable last rose, and chip enable does not fall again until at least 160 ns after `psram_oe_n` returns high.
- R7: After the first refresh, successive refresh starts are at most `REF_PERIOD_NS` (15.6 µs) plus one access apart, and refreshes continue while the host is idle.
- R8: A due refresh wins over a waiting host request. `req_ready` is low while a refresh is due or running, and a request is accepted only on an edge where `req_valid` and `req_ready` are both high. An access in progress is never cut short, and no waiting request is lost.
- R9: For reads, `psram_dq_oe` is low in the cycle before and the cycle in which `psram_oe_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period `CLK_NS` |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W | Read byte |
| psram_ce_n | output | 1 | Memory chip enable, active low |
| psram_we_n | output | 1 | Memory write strobe, active low |
| psram_oe_n | output | 1 | Output enable, or refresh request when chip enable is high, active low |
| psram_addr | output | ADDR_W | Memory address |
| psram_dq_out | output | DATA_W | Byte driven toward the memory |
| psram_dq_oe | output | 1 | Drive enable for `psram_dq_out` |
| psram_dq_in | input | DATA_W | Byte returned by the memory |

## Verification
Assertions check the pin relationships that hold on every cycle. The address is held while chip enable is low. The write strobe appears only inside a chip-enable window. A refresh pulse only starts from a chip-enable-high state. The data bus is released before output enable falls. The response strobe is single-cycle. `req_ready` is never high while a memory cycle is running, and a due refresh stays pending until it is served. The nanosecond window checks (pulse widths, precharge, refresh recovery, refresh spacing) and the power-up sequence are measured by the bench's timing-aware memory model. The same model shows data integrity across refreshes that fall inside a stream of reads; only it can show these, because the model returns valid data only once the access time has elapsed.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_DUMMY_ACT,
    ST_DUMMY_PRE,
    ST_IDLE,
    ST_ACT,
    ST_PRE,
    ST_REF_LOW,
    ST_REF_REC
  } ctrl_state_t;

  // Whole clocks covering a duration in ns (rounded up).
  function automatic int ns2clk(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= CNT_W'(RST_VAL);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!load && !expired) |=> (cnt == $past(cnt) - 1'b1)); // R5

endmodule

// File: rtl/psram_refresh_timer.sv
module psram_refresh_timer #(
  parameter int PERIOD_CLKS = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pending
);

  localparam int CW = $clog2(PERIOD_CLKS + 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(PERIOD_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end

  AST_PENDING_HELD: assert property (@(posedge clk) disable iff (rst)
    (pending && !ack) |=> pending); // R7

endmodule

// File: rtl/psram_host_ctrl.sv
module psram_host_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int CLK_NS        = 10,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int INIT_NS       = 100000,
  parameter int DUMMY_CYCLES  = 8,
  parameter int REF_PERIOD_NS = 15600,
  parameter int T_ACCESS_NS   = 80,
  parameter int T_OE_ACC_NS   = 30,
  parameter int T_CYCLE_NS    = 140,
  parameter int T_PRECH_NS    = 50,
  parameter int T_REF_LOW_NS  = 30,
  parameter int T_REF_CYC_NS  = 130,
  parameter int T_REF_CE_NS   = 160
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              psram_ce_n,
  output logic              psram_we_n,
  output logic              psram_oe_n,
  output logic [ADDR_W-1:0] psram_addr,
  output logic [DATA_W-1:0] psram_dq_out,
  output logic              psram_dq_oe,
  input  logic [DATA_W-1:0] psram_dq_in
);

  // Output enable follows chip enable by one clock, so the active phase
  // must cover both the chip-enable access time and the OE access time.
  localparam int ACT_CLKS = max2(ns2clk(T_ACCESS_NS, CLK_NS), 1 + ns2clk(T_OE_ACC_NS, CLK_NS));
  localparam int PRE_CLKS = max2(max2(ns2clk(T_PRECH_NS, CLK_NS),
                                      ns2clk(T_CYCLE_NS, CLK_NS) - ACT_CLKS), 1);
  localparam int RLO_CLKS = max2(ns2clk(T_REF_LOW_NS, CLK_NS), 1);
  localparam int RRC_CLKS = max2(ns2clk(T_REF_CE_NS, CLK_NS),
                                 ns2clk(T_REF_CYC_NS, CLK_NS) - RLO_CLKS);
  localparam int INIT_CLKS = ns2clk(INIT_NS, CLK_NS);
  localparam int REF_CLKS  = REF_PERIOD_NS / CLK_NS;
  localparam int CNT_W     = $clog2(max2(INIT_CLKS, max2(RRC_CLKS, ACT_CLKS)) + 2);
  localparam int DUM_W     = $clog2(DUMMY_CYCLES + 1);

  ctrl_state_t      state, state_d;
  logic             t_exp, t_load;
  logic [CNT_W-1:0] t_val;
  logic             ref_pend, ref_ack;
  logic             accept, wr_q, wr_d;
  logic [DUM_W-1:0] dummy_left;

  psram_phase_timer #(.CNT_W(CNT_W), .RST_VAL(INIT_CLKS)) u_phase (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  psram_refresh_timer #(.PERIOD_CLKS(REF_CLKS)) u_refresh (
    .clk(clk), .rst(rst), .ack(ref_ack), .pending(ref_pend)
  );

  assign req_ready = (state == ST_IDLE) && !ref_pend;
  assign accept    = req_valid && req_ready;
  assign ref_ack   = (state == ST_IDLE) && ref_pend;
  assign wr_d      = accept ? req_write : wr_q;

  always_comb begin
    state_d = state;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state)
      ST_INIT: if (t_exp) begin
        state_d = ST_DUMMY_ACT; t_load = 1'b1; t_val = CNT_W'(ACT_CLKS - 1);
      end
      ST_DUMMY_ACT: if (t_exp) begin
        state_d = ST_DUMMY_PRE; t_load = 1'b1; t_val = CNT_W'(PRE_CLKS - 1);
      end
      ST_DUMMY_PRE: if (t_exp) begin
        if (dummy_left == DUM_W'(1)) state_d = ST_IDLE;
        else begin
          state_d = ST_DUMMY_ACT; t_load = 1'b1; t_val = CNT_W'(ACT_CLKS - 1);
        end
      end
      ST_IDLE: begin
        if (ref_pend) begin
          state_d = ST_REF_LOW; t_load = 1'b1; t_val = CNT_W'(RLO_CLKS - 1);
        end else if (accept) begin
          state_d = ST_ACT; t_load = 1'b1; t_val = CNT_W'(ACT_CLKS - 1);
        end
      end
      ST_ACT: if (t_exp) begin
        state_d = ST_PRE; t_load = 1'b1; t_val = CNT_W'(PRE_CLKS - 1);
      end
      ST_PRE: if (t_exp) state_d = ST_IDLE;
      ST_REF_LOW: if (t_exp) begin
        state_d = ST_REF_REC; t_load = 1'b1; t_val = CNT_W'(RRC_CLKS - 1);
      end
      ST_REF_REC: if (t_exp) state_d = ST_IDLE;
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_INIT;
      dummy_left   <= DUM_W'(DUMMY_CYCLES);
      wr_q         <= 1'b0;
      psram_ce_n   <= 1'b1;
      psram_we_n   <= 1'b1;
      psram_oe_n   <= 1'b1;
      psram_dq_oe  <= 1'b0;
      psram_addr   <= '0;
      psram_dq_out <= '0;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
    end else begin
      state <= state_d;
      if (state == ST_DUMMY_PRE && t_exp) dummy_left <= dummy_left - 1'b1;
      if (accept) begin
        wr_q         <= req_write;
        psram_addr   <= req_addr;
        psram_dq_out <= req_wdata;
      end
      psram_ce_n  <= !(state_d == ST_ACT || state_d == ST_DUMMY_ACT);
      psram_we_n  <= !(state_d == ST_ACT && wr_d);
      psram_oe_n  <= !((state_d == ST_ACT && state == ST_ACT && !wr_q) ||
                       state_d == ST_REF_LOW);
      psram_dq_oe <= (state_d == ST_ACT || state_d == ST_PRE) && wr_d;
      rsp_valid   <= (state == ST_ACT) && t_exp && !wr_q;
      if ((state == ST_ACT) && t_exp && !wr_q) rsp_rdata <= psram_dq_in;
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!psram_ce_n && !$past(psram_ce_n)) |-> $stable(psram_addr)); // R4
  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (rst)
    !psram_we_n |-> !psram_ce_n); // R3
  AST_REFRESH_FROM_CE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!psram_oe_n && psram_ce_n) |-> $past(psram_ce_n)); // R6
  AST_BUS_FREE_AT_OE: assert property (@(posedge clk) disable iff (rst)
    (!psram_oe_n && !psram_ce_n) |-> (!psram_dq_oe && !$past(psram_dq_oe))); // R9
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R2
  AST_READY_ONLY_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (psram_ce_n && psram_oe_n && !ref_pend)); // R8

endmodule

// File: tb/test_psram_host_ctrl.sv
module test_psram_host_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic       req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic       ce_n, we_n, oe_n, dq_oe;
  logic [15:0] addr;
  logic [7:0] dq_out;
  logic [7:0] dq_in = 8'hEE;

  always #5 clk = ~clk;

  psram_host_ctrl i_psram_host_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .psram_ce_n(ce_n), .psram_we_n(we_n), .psram_oe_n(oe_n),
    .psram_addr(addr), .psram_dq_out(dq_out), .psram_dq_oe(dq_oe),
    .psram_dq_in(dq_in)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic [7:0] model_mem [int];
  logic [7:0] shadow [int];
  logic [7:0] exp_q [$];
  logic [7:0] exp_b;

  // ---------------- timing-aware memory model and monitor ----------------
  longint t_rel = 0, t_ce_fall = -1, t_ce_rise = -100000, t_oe_fall = -1;
  longint t_we_fall = -1, t_ref_start = -1, t_ref_end = -100000, now;
  logic   p_ce = 1, p_oe = 1, p_we = 1, p_dq_oe = 0;
  logic [7:0]  p_dq_out = '0;
  logic [15:0] a_lat = '0;
  bit     in_ref = 0, ready_seen = 0;
  int     dummy_cnt = 0, ref_cnt = 0;

  always @(negedge clk) begin
    if (!rst) begin
      now = $time - 5;  // time of the preceding rising edge
      if (p_ce && !ce_n) begin
        chk(oe_n == 1'b1, "R5 oe_n high at ce fall", oe_n, 1);
        chk(now - t_ce_rise >= 50, "R5 ce precharge ns", now - t_ce_rise, 50);
        if (t_ce_fall >= 0)
          chk(now - t_ce_fall >= 140, "R5 cycle ns", now - t_ce_fall, 140);
        chk(now - t_ref_end >= 160, "R6 ce after refresh ns", now - t_ref_end, 160);
        chk(!in_ref, "R8 access during refresh", in_ref, 0);
        if (!ready_seen) begin
          if (dummy_cnt == 0)
            chk(now - t_rel >= 100000, "R1 quiet time ns", now - t_rel, 100000);
          dummy_cnt++;
          chk(oe_n && we_n, "R1 dummy cycle strobes", {oe_n, we_n}, 3);
        end
        a_lat = addr;
        t_ce_fall = now;
      end
      if (!p_ce && ce_n) begin
        chk(now - t_ce_fall >= 80 && now - t_ce_fall <= 10000, "R5 ce width ns",
            now - t_ce_fall, 80);
        chk(addr == a_lat, "R4 address held", addr, a_lat);
        t_ce_rise = now;
      end
      if (p_we && !we_n) begin
        chk(!ce_n, "R3 we inside ce", ce_n, 0);
        t_we_fall = now;
      end
      if (!p_we && we_n) begin
        chk(p_dq_oe, "R3 data driven at we rise", p_dq_oe, 1);
        chk(now - t_we_fall >= 30, "R3 we width ns", now - t_we_fall, 30);
        model_mem[int'(a_lat)] = p_dq_out;
      end
      if (p_oe && !oe_n) begin
        if (ce_n) begin
          in_ref = 1;
          ref_cnt++;
          chk(p_ce, "R6 refresh with ce high", p_ce, 1);
          chk(now - t_ce_rise >= 50, "R6 refresh after ce ns", now - t_ce_rise, 50);
          chk(!req_ready, "R8 ready low in refresh", req_ready, 0);
          if (ref_cnt >= 2)
            chk(now - t_ref_start <= 15600 + 300, "R7 refresh gap ns",
                now - t_ref_start, 15600);
          t_ref_start = now;
        end else begin
          chk(!p_dq_oe && !dq_oe, "R9 bus released at oe", {p_dq_oe, dq_oe}, 0);
          t_oe_fall = now;
        end
      end
      if (!p_oe && oe_n && in_ref) begin
        chk(now - t_ref_start >= 30 && now - t_ref_start <= 8000, "R6 refresh width ns",
            now - t_ref_start, 30);
        t_ref_end = now;
        in_ref = 0;
      end
      if (req_ready && !ready_seen) begin
        ready_seen = 1;
        chk(dummy_cnt == 8, "R1 dummy cycle count", dummy_cnt, 8);
      end
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(0, "R2 unexpected response", rsp_rdata, -1);
        else begin
          exp_b = exp_q.pop_front();
          chk(rsp_rdata == exp_b, "R2 read data", rsp_rdata, exp_b);
        end
      end
      // read data is valid only after both access times at the next rising edge
      if (!ce_n && !oe_n && we_n && (now + 10 - t_ce_fall >= 80) && (now + 10 - t_oe_fall >= 30))
        dq_in = model_mem.exists(int'(a_lat)) ? model_mem[int'(a_lat)] : 8'h5A;
      else
        dq_in = 8'hEE;
      p_ce = ce_n; p_oe = oe_n; p_we = we_n; p_dq_oe = dq_oe; p_dq_out = dq_out;
    end
  end

  // ---------------- driver ----------------
  task automatic do_req(input bit wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (wr) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h5A);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    int r0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(ce_n && oe_n && we_n, "R1 reset strobes high", {ce_n, oe_n, we_n}, 7);
    chk(!dq_oe && !req_ready && !rsp_valid, "R1 reset idle outputs",
        {dq_oe, req_ready, rsp_valid}, 0);
    rst = 1'b0;
    t_rel = $time;
    repeat (5000) @(negedge clk);
    chk(ce_n && oe_n && !req_ready, "R1 quiet during init", {ce_n, oe_n, req_ready}, 6);
    while (!ready_seen) @(negedge clk);

    do_req(0, 16'h1234, 0);                   // R2 unwritten location
    do_req(1, 16'h0000, 8'hA5);               // R3 lowest address
    do_req(1, 16'hFFFF, 8'h3C);               // R3 highest address
    do_req(1, 16'h8001, 8'h0F);
    do_req(0, 16'h0000, 0);
    do_req(0, 16'hFFFF, 0);
    do_req(1, 16'h8001, 8'hF0);               // overwrite
    do_req(0, 16'h8001, 0);
    for (int i = 0; i < 40; i++) begin
      do_req(1, 16'(i * 1637), 8'(i * 37 + 1));
      do_req(0, 16'(i * 1637), 0);
    end
    for (int i = 0; i < 10; i++) do_req(0, 16'(i * 1637), 0);

    r0 = ref_cnt;                              // R8 stream across refreshes
    for (int i = 0; i < 150; i++) do_req(0, 16'((i % 40) * 1637), 0);
    repeat (30) @(negedge clk);
    chk(ref_cnt > r0, "R8 refresh inside read stream", ref_cnt - r0, 1);
    chk(exp_q.size() == 0, "R8 no request lost", exp_q.size(), 0);

    r0 = ref_cnt;
    repeat (4000) @(negedge clk);
    chk(ref_cnt - r0 >= 2, "R7 refresh while idle", ref_cnt - r0, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "R1 watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule